// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two 8-bit bidirectional buses, called side A and side B. It has one storage register for each direction. The A-to-B register samples side A on the rising edge of its own capture clock. The B-to-A register samples side B on the rising edge of a second, independent capture clock. An active-low output enable and a direction input decide which side, if either, the block drives. A source select for each direction chooses what is driven: either the live value from the opposite side, or the value held in that direction's register.

Each bus is modelled as three signal groups: an input word, an output word and an output-enable bit. The chip's pad ring or bus fabric combines them into a real bidirectional net, so the block itself contains no tristate logic. Capture does not depend on the output controls. A value can therefore be stored while both sides are isolated, and a stored value can be replayed onto one side while the other side keeps changing.

Top module: `reg_bus_xcvr`

## Requirements
- R1: Both data paths are 8 bits wide and non-inverting: bit n of an output word comes from bit n of its source.
- R2: When `xcvr_oe_n` is 1, both `a_drive` and `b_drive` are 0. `a_dout` and `b_dout` still carry the selected source value, even though neither is enabled.
- R3: When `xcvr_oe_n` is 0 and `dir_sel` is 0, `a_drive` is 1, `b_drive` is 0, and side A receives data from the B side.
- R4: When `xcvr_oe_n` is 0 and `dir_sel` is 1, `b_drive` is 1, `a_drive` is 0, and side B receives data from the A side.
- R5: The A-to-B register loads `a_din` on each rising edge of `cap_clk_ab`. The B-to-A register loads `b_din` on each rising edge of `cap_clk_ba`. An edge on one clock leaves the other register unchanged.
- R6: Capture happens whatever the values of `xcvr_oe_n` and `dir_sel`. This includes isolation, and also the case where the captured side is the one being driven.
- R7: `b_dout` equals `a_din` when `src_ab` is 0, and equals the A-to-B register when `src_ab` is 1.
- R8: `a_dout` equals `b_din` when `src_ba` is 0, and equals the B-to-A register when `src_ba` is 1.
- R9: `a_drive` and `b_drive` are never 1 at the same time.
- R10: While `rst_n` is 0, both registers read 0, and this takes effect at once, with no clock edge. After `rst_n` rises, each register stays at 0 for its first 2 rising capture-clock edges and captures from the third edge onwards.
- R11: A falling edge of a capture clock, or a change of the input while that clock is high, does not change the stored value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cap_clk_ab | input | 1 | Capture clock of the A-to-B register (rising edge) |
| cap_clk_ba | input | 1 | Capture clock of the B-to-A register (rising edge) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each clock domain |
| xcvr_oe_n | input | 1 | Output enable, active low; 1 selects isolation |
| dir_sel | input | 1 | 0 drives side A, 1 drives side B |
| src_ab | input | 1 | Source toward side B: 0 live side A, 1 stored A-to-B word |
| src_ba | input | 1 | Source toward side A: 0 live side B, 1 stored B-to-A word |
| a_din | input | 8 | Value seen on bus A |
| a_dout | output | 8 | Value offered to bus A |
| a_drive | output | 1 | Enable for driving bus A |
| b_din | input | 8 | Value seen on bus B |
| b_dout | output | 8 | Value offered to bus B |
| b_drive | output | 1 | Enable for driving bus B |

## Verification
Some properties are checked by assertions on every cycle:
- the two drive enables are never both high;
- isolation forces both enables low;
- each register takes its source value one edge after a qualifying capture edge;
- both registers hold zero while their synchronized reset is low.

Other behaviour only the bench scenarios can show:
- the live-versus-stored selection in both directions;
- storing both words during isolation;
- replaying a stored word while the opposite bus changes;
- the two-edge delay after reset release;
- the fact that falling edges, and input changes while a clock is high, leave the stored words alone.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int XCVR_WIDTH = 8;
  localparam int XCVR_SYNC_STAGES = 2;

  typedef enum logic {
    DRIVE_SIDE_A = 1'b0,
    DRIVE_SIDE_B = 1'b1
  } drive_side_e;

  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_sel_e;

  localparam int PATH_BA = 0;
  localparam int PATH_AB = 1;
  localparam int NUM_PATHS = 2;
endpackage

// File: rtl/xcvr_rst_sync.sv
module xcvr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic [LAST:0] chain_d;

  // Shift ones in from the bottom once the asynchronous reset is released.
  always_comb begin
    chain_d = {chain_q[LAST-1:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[LAST];
endmodule

// File: rtl/xcvr_cap_reg.sv
module xcvr_cap_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] q_d;

  // Every rising edge of the capture clock is a load.
  always_comb begin
    q_d = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      q <= q_d;
    end
  end

  // R5: a capture edge taken outside reset stores the source word.
  assert_capture_load_R5: assert property (
    @(posedge clk) disable iff (!rst_n)
    rst_n |=> q == $past(d)
  ) else $error("capture register did not load its source word");

  // R10: while reset is held, the register reads zero.
  assert_reset_clear_R10: assert property (
    @(posedge clk) !rst_n |-> q == '0
  ) else $error("capture register not cleared during reset");
endmodule

// File: rtl/xcvr_steer.sv
module xcvr_steer
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             oe_n,
  input  logic             dir,
  input  logic             src_ab,
  input  logic             src_ba,
  input  logic [WIDTH-1:0] a_live,
  input  logic [WIDTH-1:0] b_live,
  input  logic [WIDTH-1:0] held_ab,
  input  logic [WIDTH-1:0] held_ba,
  output logic [WIDTH-1:0] to_a,
  output logic [WIDTH-1:0] to_b,
  output logic             en_a,
  output logic             en_b
);
  drive_side_e side;
  src_sel_e    pick_ab;
  src_sel_e    pick_ba;

  always_comb begin
    side    = drive_side_e'(dir);
    pick_ab = src_sel_e'(src_ab);
    pick_ba = src_sel_e'(src_ba);

    to_b = (pick_ab == SRC_STORED) ? held_ab : a_live;
    to_a = (pick_ba == SRC_STORED) ? held_ba : b_live;

    en_a = 1'b0;
    en_b = 1'b0;
    if (!oe_n) begin
      if (side == DRIVE_SIDE_B) begin
        en_b = 1'b1;
      end else begin
        en_a = 1'b1;
      end
    end
  end
endmodule

// File: rtl/reg_bus_xcvr.sv
module reg_bus_xcvr
  import xcvr_pkg::*;
#(
  parameter int WIDTH       = XCVR_WIDTH,
  parameter int SYNC_STAGES = XCVR_SYNC_STAGES
) (
  input  logic             cap_clk_ab,
  input  logic             cap_clk_ba,
  input  logic             rst_n,
  input  logic             xcvr_oe_n,
  input  logic             dir_sel,
  input  logic             src_ab,
  input  logic             src_ba,
  input  logic [WIDTH-1:0] a_din,
  output logic [WIDTH-1:0] a_dout,
  output logic             a_drive,
  input  logic [WIDTH-1:0] b_din,
  output logic [WIDTH-1:0] b_dout,
  output logic             b_drive
);
  logic [NUM_PATHS-1:0] path_clk;
  logic [NUM_PATHS-1:0] path_rst_n;
  logic [WIDTH-1:0]     path_src  [NUM_PATHS];
  logic [WIDTH-1:0]     path_held [NUM_PATHS];

  assign path_clk[PATH_AB] = cap_clk_ab;
  assign path_clk[PATH_BA] = cap_clk_ba;
  assign path_src[PATH_AB] = a_din;
  assign path_src[PATH_BA] = b_din;

  // One reset synchronizer and one capture register per direction,
  // each in the domain of its own capture clock.
  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
    xcvr_rst_sync #(
      .STAGES(SYNC_STAGES)
    ) u_rst_sync (
      .clk        (path_clk[p]),
      .rst_n_async(rst_n),
      .rst_n_sync (path_rst_n[p])
    );

    xcvr_cap_reg #(
      .WIDTH(WIDTH)
    ) u_cap (
      .clk  (path_clk[p]),
      .rst_n(path_rst_n[p]),
      .d    (path_src[p]),
      .q    (path_held[p])
    );
  end

  xcvr_steer #(
    .WIDTH(WIDTH)
  ) u_steer (
    .oe_n   (xcvr_oe_n),
    .dir    (dir_sel),
    .src_ab (src_ab),
    .src_ba (src_ba),
    .a_live (a_din),
    .b_live (b_din),
    .held_ab(path_held[PATH_AB]),
    .held_ba(path_held[PATH_BA]),
    .to_a   (a_dout),
    .to_b   (b_dout),
    .en_a   (a_drive),
    .en_b   (b_drive)
  );

  always_comb begin
    // R9: the two sides are never driven together.
    assert_single_driver_R9: assert (!(a_drive && b_drive))
      else $error("both bus sides driven");
    // R2: isolation releases both sides.
    assert_isolation_R2: assert (!xcvr_oe_n || (!a_drive && !b_drive))
      else $error("a side is driven during isolation");
  end
endmodule

// File: tb/reg_bus_xcvr_test.sv
module reg_bus_xcvr_test;
  localparam int W = 8;
  localparam int WATCHDOG = 100000;

  logic         clk;
  logic         cap_clk_ab, cap_clk_ba, rst_n;
  logic         xcvr_oe_n, dir_sel, src_ab, src_ba;
  logic [W-1:0] a_din, b_din, a_dout, b_dout;
  logic         a_drive, b_drive;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  logic done = 1'b0;

  reg_bus_xcvr uut (
    .cap_clk_ab(cap_clk_ab), .cap_clk_ba(cap_clk_ba), .rst_n(rst_n),
    .xcvr_oe_n(xcvr_oe_n), .dir_sel(dir_sel), .src_ab(src_ab), .src_ba(src_ba),
    .a_din(a_din), .a_dout(a_dout), .a_drive(a_drive),
    .b_din(b_din), .b_dout(b_dout), .b_drive(b_drive)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG && !done) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  typedef struct packed {
    logic       oe_n, dir, s_ab, s_ba;
    logic [7:0] a, b;
    logic       x_aen, x_ben;
    logic [7:0] x_aout, x_bout;
  } vec_t;

  // Stored words during the table: A-to-B = 8'h5A, B-to-A = 8'hC3.
  localparam vec_t VECS [8] = '{
    '{1'b1, 1'b0, 1'b0, 1'b0, 8'h11, 8'h22, 1'b0, 1'b0, 8'h22, 8'h11},
    '{1'b0, 1'b0, 1'b0, 1'b0, 8'h33, 8'h44, 1'b1, 1'b0, 8'h44, 8'h33},
    '{1'b0, 1'b0, 1'b0, 1'b1, 8'h55, 8'h66, 1'b1, 1'b0, 8'hC3, 8'h55},
    '{1'b0, 1'b1, 1'b0, 1'b0, 8'h77, 8'h88, 1'b0, 1'b1, 8'h88, 8'h77},
    '{1'b0, 1'b1, 1'b1, 1'b0, 8'h99, 8'hAA, 1'b0, 1'b1, 8'hAA, 8'h5A},
    '{1'b1, 1'b1, 1'b1, 1'b1, 8'h01, 8'h80, 1'b0, 1'b0, 8'hC3, 8'h5A},
    '{1'b0, 1'b1, 1'b0, 1'b0, 8'hFF, 8'h00, 1'b0, 1'b1, 8'h00, 8'hFF},
    '{1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 8'hFF, 1'b1, 1'b0, 8'hC3, 8'h5A}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic pulse_ab();
    #2 cap_clk_ab = 1'b1;
    #3 cap_clk_ab = 1'b0;
    #2;
  endtask

  task automatic pulse_ba();
    #2 cap_clk_ba = 1'b1;
    #3 cap_clk_ba = 1'b0;
    #2;
  endtask

  task automatic ctrl(input logic oe_n, input logic dir, input logic sab, input logic sba);
    xcvr_oe_n = oe_n; dir_sel = dir; src_ab = sab; src_ba = sba;
    #1;
  endtask

  initial begin
    rst_n = 1'b1; cap_clk_ab = 1'b0; cap_clk_ba = 1'b0;
    a_din = '0; b_din = '0;
    xcvr_oe_n = 1'b1; dir_sel = 1'b0; src_ab = 1'b1; src_ba = 1'b1;
    #1 rst_n = 1'b0;
    #4;

    // Reset state: stored words read back as zero, and isolation.
    check("R10 reset stored A-to-B", b_dout, 8'h00);
    check("R10 reset stored B-to-A", a_dout, 8'h00);
    check("R2 reset isolation a_drive", {7'd0, a_drive}, 8'h00);
    check("R2 reset isolation b_drive", {7'd0, b_drive}, 8'h00);

    // Release reset: the first two edges of each clock must not capture.
    #3 rst_n = 1'b1;
    a_din = 8'hAA; b_din = 8'hBB;
    pulse_ab(); pulse_ab(); pulse_ba(); pulse_ba();
    check("R10 no capture during sync A-to-B", b_dout, 8'h00);
    check("R10 no capture during sync B-to-A", a_dout, 8'h00);

    // Isolation, store both words (third edges capture).
    a_din = 8'h5A; b_din = 8'hC3;
    pulse_ab(); pulse_ba();
    a_din = 8'h00; b_din = 8'h00; #1;
    check("R6 isolation store A-to-B", b_dout, 8'h5A);
    check("R6 isolation store B-to-A", a_dout, 8'hC3);
    check("R2 isolation no drive", {6'd0, a_drive, b_drive}, 8'h00);

    // Table of control and data patterns.
    for (int i = 0; i < 8; i++) begin
      a_din = VECS[i].a; b_din = VECS[i].b;
      ctrl(VECS[i].oe_n, VECS[i].dir, VECS[i].s_ab, VECS[i].s_ba);
      check($sformatf("R3/R4 vec %0d a_drive", i), {7'd0, a_drive}, {7'd0, VECS[i].x_aen});
      check($sformatf("R3/R4 vec %0d b_drive", i), {7'd0, b_drive}, {7'd0, VECS[i].x_ben});
      check($sformatf("R8 R1 vec %0d a_dout", i), a_dout, VECS[i].x_aout);
      check($sformatf("R7 R1 vec %0d b_dout", i), b_dout, VECS[i].x_bout);
      check($sformatf("R9 vec %0d single driver", i), {7'd0, a_drive & b_drive}, 8'h00);
    end

    // Capture while side B is driven with the stored word; other register untouched.
    ctrl(1'b0, 1'b1, 1'b1, 1'b1);
    a_din = 8'h3C;
    pulse_ab();
    check("R6 capture while driving B", b_dout, 8'h3C);
    check("R5 B-to-A unchanged by A-to-B clock", a_dout, 8'hC3);

    // Replay the stored word while the opposite bus changes.
    for (int v = 0; v < 4; v++) begin
      a_din = 8'(v * 8'h47 + 8'h11); #1;
      check("R7 replay stable while A changes", b_dout, 8'h3C);
    end
    ctrl(1'b0, 1'b0, 1'b1, 1'b1);
    for (int v = 0; v < 4; v++) begin
      b_din = 8'(v * 8'h29 + 8'h05); #1;
      check("R8 replay stable while B changes", a_dout, 8'hC3);
      check("R3 side A driven", {6'd0, a_drive, b_drive}, 8'h02);
    end

    // Falling edge and changes while the clock is high must not capture.
    a_din = 8'h11;
    #2 cap_clk_ab = 1'b1;
    #2 a_din = 8'hE7;
    #2 cap_clk_ab = 1'b0;
    #2;
    check("R11 no capture on high level or falling edge", b_dout, 8'h11);
    b_din = 8'h6D;
    #2 cap_clk_ba = 1'b1;
    #2 b_din = 8'h92;
    #2 cap_clk_ba = 1'b0;
    #2;
    check("R11 B-to-A held after falling edge", a_dout, 8'h6D);
    check("R5 A-to-B unchanged by B-to-A clock", b_dout, 8'h11);

    // Reset in mid-operation clears at once.
    #1 rst_n = 1'b0;
    #1;
    check("R10 async clear A-to-B", b_dout, 8'h00);
    check("R10 async clear B-to-A", a_dout, 8'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule